// File: doc/BRIEF.md
# SPI Slave Hold Controller

This block manages the pause function of an SPI slave port. It watches the chip-select, serial clock and hold-request pins in the system clock domain. From them it produces a hold indication that stops the slave's shift logic and releases the serial data output. It also produces qualified shift strobes, which are serial clock edges that the shift registers may act on.

A hold may only begin or end while the serial clock is low. If the hold pin changes while the clock is high, the change is postponed until the clock falls. If chip-select is released during a hold, the controller raises a one-cycle interface reset request. It then refuses any new selection until the hold pin has returned high and chip-select has been released again.

Internal status-write, program or erase operations are not governed by this block and keep running during a hold. All pins pass through a synchronizer of `SYNC_STAGES` flops. Outputs therefore follow a pin change after a fixed delay of a few system clock cycles.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_active_o, so_oe_o, sel_blocked_o, if_reset_o and both shift strobes are all 0.
- R2: With cs_n_i low and hold_n_i high, so_oe_o is 1. Every serial clock rising edge gives one shift_rise_o pulse and every falling edge gives one shift_fall_o pulse.
- R3: While selected with sclk_i low, driving hold_n_i low sets hold_active_o to 1 and so_oe_o to 0.
- R4: If hold_n_i falls while sclk_i is high, hold_active_o stays 0 and so_oe_o stays 1 until sclk_i goes low. At that point the hold begins.
- R5: If hold_n_i rises during a hold while sclk_i is high, hold_active_o stays 1 until sclk_i goes low. Then so_oe_o returns to 1.
- R6: While hold_active_o is 1, serial clock edges produce no shift strobes.
- R7: Raising cs_n_i during a hold produces exactly one if_reset_o pulse of one cycle. hold_active_o is forced to 0 and sel_blocked_o becomes 1.
- R8: While sel_blocked_o is 1, lowering cs_n_i does not select the slave (so_oe_o and hold_active_o stay 0, no strobes). The block clears only once hold_n_i is high and cs_n_i is high together.
- R9: Raising cs_n_i outside a hold sets so_oe_o to 0 and produces no if_reset_o pulse.
- R10: If hold_n_i falls and rises again while sclk_i stays high, no hold occurs. The next falling edge gives a normal shift_fall_o strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| hold_n_i | input | 1 | Hold request pin, active low, asynchronous |
| hold_active_o | output | 1 | Hold in force; freeze shift logic |
| so_oe_o | output | 1 | Serial output drive enable (0 = high impedance) |
| shift_rise_o | output | 1 | Qualified serial clock rising edge strobe |
| shift_fall_o | output | 1 | Qualified serial clock falling edge strobe |
| if_reset_o | output | 1 | One-cycle interface reset request |
| sel_blocked_o | output | 1 | New selections refused until hold pin is high |

## Verification
The hardest states to reach are the two postponed transitions: a hold requested while the serial clock is high, and a hold released while the serial clock is high. Each needs the hold pin to change inside a single clock-high phase. The stimulus holds every serial clock level for several system cycles. It changes the hold pin only in the middle of a high phase and checks the outputs before and after the following fall. The lockout after a deselect-in-hold is reached by reselecting with the hold pin still low, so the refusal can be seen at the output enable.

// File: rtl/spi_hold_pkg.sv
// Shared types for the SPI hold controller.
package spi_hold_pkg;

    // Controller states. "Pend" states wait for the serial clock to go low.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,  // deselected
        ST_RUN       = 3'd1,  // selected, shifting allowed
        ST_ENTER_PND = 3'd2,  // hold requested, clock still high
        ST_HOLD      = 3'd3,  // hold in force
        ST_EXIT_PND  = 3'd4,  // hold released, clock still high
        ST_LOCK      = 3'd5   // deselected in hold, awaiting hold pin high
    } hold_state_e;

    // Bit positions of the pins inside the synchronizer vector.
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_HOLD = 2;
    localparam int PIN_CNT  = 3;

endpackage

// File: rtl/spi_hold_sync.sv
// Multi-bit flop synchronizer.
// Assumes each bit is an independent slow level (no bus coherence needed).
// Each bit resets to its entry in RST_VAL.
module spi_hold_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d_i;
                end
            end else begin : g_next
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
// Edge detector for a synchronized level.
// Assumes the input is already in the clk domain.
module spi_hold_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= RST_VAL;
        else        lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
    assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/spi_hold_fsm.sv
// Hold sequencing state machine.
// Changes of the hold pin take effect only while the serial clock is low.
// Deselecting during a hold requests an interface reset and locks out
// new selections until the hold pin returns high with chip select high.
// Assumes all inputs are synchronized to clk.
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic hold_n,
    output logic hold_active,
    output logic so_oe,
    output logic shift_ok,
    output logic if_reset,
    output logic blocked
);
    hold_state_e state_q, state_d;
    logic        in_hold;
    logic        rst_req_q;

    assign in_hold = (state_q == ST_HOLD) || (state_q == ST_EXIT_PND);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (!cs_n) state_d = ST_RUN;
            ST_RUN: begin
                if (cs_n)         state_d = ST_IDLE;
                else if (!hold_n) state_d = sclk ? ST_ENTER_PND : ST_HOLD;
            end
            ST_ENTER_PND: begin
                if (cs_n)        state_d = ST_IDLE;
                else if (hold_n) state_d = ST_RUN;
                else if (!sclk)  state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_n)        state_d = ST_LOCK;
                else if (hold_n) state_d = sclk ? ST_EXIT_PND : ST_RUN;
            end
            ST_EXIT_PND: begin
                if (cs_n)         state_d = ST_LOCK;
                else if (!hold_n) state_d = ST_HOLD;
                else if (!sclk)   state_d = ST_RUN;
            end
            ST_LOCK:      if (hold_n && cs_n) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // One-cycle reset request when chip select rises inside a hold.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req_q <= 1'b0;
        else        rst_req_q <= in_hold && cs_n;
    end

    assign hold_active = in_hold && !cs_n;
    assign so_oe       = ((state_q == ST_RUN) || (state_q == ST_ENTER_PND)) && !cs_n;
    assign shift_ok    = (state_q == ST_RUN) && !cs_n;
    assign if_reset    = rst_req_q;
    assign blocked     = (state_q == ST_LOCK);

    // R3/R4: a hold only begins while the clock is low.
    a_r4_entry_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> !sclk);
    // R5: a hold ending back into shifting only happens with the clock low.
    a_r5_exit_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_active) && so_oe) |-> !sclk);
    // R7: the reset request lasts one cycle.
    a_r7_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |=> !if_reset);
    // R7: the reset request comes with the lockout.
    a_r7_reset_locks: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |-> blocked);
    // R8: nothing is driven while locked out.
    a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (!so_oe && !hold_active));
    // R3: output drive and hold are mutually exclusive.
    a_r3_oe_vs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(so_oe && hold_active));
endmodule

// File: rtl/spi_hold_ctrl.sv
// Top of the SPI hold controller.
// Synchronizes the three pins, finds serial clock edges, and lets them
// through as shift strobes only when the sequencer allows shifting.
// Assumes the pins are slow relative to clk (several clk per SCLK level).
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic hold_n_i,
    output logic hold_active_o,
    output logic so_oe_o,
    output logic shift_rise_o,
    output logic shift_fall_o,
    output logic if_reset_o,
    output logic sel_blocked_o
);
    localparam logic [PIN_CNT-1:0] PIN_RST = 3'b101;

    logic [PIN_CNT-1:0] pins_raw, pins_s;
    logic               sclk_rise, sclk_fall, shift_ok;

    assign pins_raw[PIN_CS]   = cs_n_i;
    assign pins_raw[PIN_SCLK] = sclk_i;
    assign pins_raw[PIN_HOLD] = hold_n_i;

    spi_hold_sync #(
        .WIDTH   (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    spi_hold_edge #(.RST_VAL(PIN_RST[PIN_SCLK])) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_s[PIN_SCLK]),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    spi_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (pins_s[PIN_CS]),
        .sclk        (pins_s[PIN_SCLK]),
        .hold_n      (pins_s[PIN_HOLD]),
        .hold_active (hold_active_o),
        .so_oe       (so_oe_o),
        .shift_ok    (shift_ok),
        .if_reset    (if_reset_o),
        .blocked     (sel_blocked_o)
    );

    assign shift_rise_o = sclk_rise & shift_ok;
    assign shift_fall_o = sclk_fall & shift_ok;

    // R6: no strobe leaves the block during a hold.
    a_r6_no_strobe_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active_o |-> !(shift_rise_o || shift_fall_o));
    // R8: no strobe leaves the block while locked out.
    a_r8_no_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
        sel_blocked_o |-> !(shift_rise_o || shift_fall_o));
endmodule

// File: tb/tb_spi_hold_ctrl.sv
`timescale 1ns/1ps
module tb_spi_hold_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1;
    logic hold_active, so_oe, s_rise, s_fall, if_rst, blocked;

    always #2.5 clk = ~clk;

    spi_hold_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .hold_n_i(hold_n),
        .hold_active_o(hold_active), .so_oe_o(so_oe), .shift_rise_o(s_rise),
        .shift_fall_o(s_fall), .if_reset_o(if_rst), .sel_blocked_o(blocked)
    );

    typedef struct {
        string tag;
        int    rises, falls, resets;
        bit    hold, oe, blk;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    int   c_rise = 0, c_fall = 0, c_rst = 0;
    bit   finished = 1'b0;

    // Monitor: accumulates strobes and pops expectations to compare.
    always @(negedge clk) begin
        if (rst_n) begin
            c_rise += int'(s_rise);
            c_fall += int'(s_fall);
            c_rst  += int'(if_rst);
        end
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (c_rise != e.rises || c_fall != e.falls || c_rst != e.resets ||
                hold_active != e.hold || so_oe != e.oe || blocked != e.blk) begin
                n_fail++;
                $display("FAIL %s: actual rise=%0d fall=%0d rst=%0d hold=%0b oe=%0b blk=%0b expected rise=%0d fall=%0d rst=%0d hold=%0b oe=%0b blk=%0b",
                    e.tag, c_rise, c_fall, c_rst, hold_active, so_oe, blocked,
                    e.rises, e.falls, e.resets, e.hold, e.oe, e.blk);
            end
            c_rise = 0; c_fall = 0; c_rst = 0;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: let pins settle, then queue expectations.
    task automatic expect_now(input string tag, input int r, input int f, input int rs,
                              input bit h, input bit oe, input bit bk);
        exp_t e;
        wait_cyc(8);
        e.tag = tag; e.rises = r; e.falls = f; e.resets = rs;
        e.hold = h; e.oe = oe; e.blk = bk;
        exp_q.push_back(e);
        wait_cyc(2);
    endtask

    task automatic set_sclk(input logic v);
        sclk = v;
        wait_cyc(8);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        expect_now("R1 reset state", 0, 0, 0, 0, 0, 0);

        cs_n = 1'b0;
        expect_now("R2 selected", 0, 0, 0, 0, 1, 0);
        for (int k = 0; k < 3; k++) begin
            set_sclk(1'b1);
            set_sclk(1'b0);
        end
        expect_now("R2 three clock pulses", 3, 3, 0, 0, 1, 0);

        hold_n = 1'b0;
        expect_now("R3 hold with clock low", 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 2; k++) begin
            set_sclk(1'b1);
            set_sclk(1'b0);
        end
        expect_now("R6 no strobes in hold", 0, 0, 0, 1, 0, 0);

        set_sclk(1'b1);
        hold_n = 1'b1;
        expect_now("R5 exit deferred while clock high", 0, 0, 0, 1, 0, 0);
        sclk = 1'b0;
        expect_now("R5 exit at clock low", 0, 0, 0, 0, 1, 0);

        set_sclk(1'b1);
        hold_n = 1'b0;
        expect_now("R4 entry deferred while clock high", 1, 0, 0, 0, 1, 0);
        sclk = 1'b0;
        expect_now("R4 entry at clock low", 0, 0, 0, 1, 0, 0);
        hold_n = 1'b1;
        expect_now("R3 release with clock low", 0, 0, 0, 0, 1, 0);

        set_sclk(1'b1);
        hold_n = 1'b0;
        wait_cyc(8);
        hold_n = 1'b1;
        expect_now("R10 cancelled entry", 1, 0, 0, 0, 1, 0);
        sclk = 1'b0;
        expect_now("R10 fall strobe after cancel", 0, 1, 0, 0, 1, 0);

        hold_n = 1'b0;
        expect_now("R3 hold before deselect", 0, 0, 0, 1, 0, 0);
        cs_n = 1'b1;
        expect_now("R7 deselect in hold", 0, 0, 1, 0, 0, 1);

        cs_n = 1'b0;
        set_sclk(1'b1);
        set_sclk(1'b0);
        expect_now("R8 reselect refused", 0, 0, 0, 0, 0, 1);
        hold_n = 1'b1;
        expect_now("R8 still locked with cs low", 0, 0, 0, 0, 0, 1);
        cs_n = 1'b1;
        expect_now("R8 lock cleared", 0, 0, 0, 0, 0, 0);
        cs_n = 1'b0;
        expect_now("R2 reselect after lock", 0, 0, 0, 0, 1, 0);

        cs_n = 1'b1;
        expect_now("R9 plain deselect", 0, 0, 0, 0, 0, 0);

        wait_cyc(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule